// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache Controller

This block holds the tags, the coherence states, the replacement bits and the line storage of a two-way set-associative data cache in a 32-bit address space. There are 128 sets of 32-byte lines. The CPU side issues one word access at a time: an address, a read or write flag, four byte enables and write data. The controller checks both ways of the selected set at once. On a miss it picks a victim and writes it back to the next memory level if it is dirty. It then fetches the missing line over a whole-line port and completes the access from the refilled line.

Each line carries one of four coherence states (Modified, Exclusive, Shared, Invalid), and each set keeps a single replacement bit that names the way to evict next. A run-time input selects how writes are handled. In write-back mode, writes stay in the cache and make the line Modified. In write-through mode, every write also sends the updated line to the next level, and no line ever becomes Modified.

Top module: `dcache_2way`

## Requirements
- R1: After reset `cpuReady` is 1, `memReq` is 0, and every line is Invalid, so the first access to any address is reported as a miss.
- R2: An access hits only when a way of the indexed set (index = address bits 11:5) holds a non-Invalid line whose tag equals address bits 31:12. A hit completes with `cpuHit`=1 and issues no memory request.
- R3: A read miss issues one line read at line address {tag, index} (`memAddr` = address bits 31:5). It installs the returned line as Exclusive and returns the requested word, selected by address bits 4:2, with `cpuHit`=0.
- R4: On a miss, an Invalid way is used first, and way 0 is preferred over way 1. Only when both ways are valid is the way named by the set's replacement bit chosen.
- R5: Every completed access sets the replacement bit of its set to the way it did not use, so the least recently used way is evicted next.
- R6: A Modified victim is written to the next level, with its own line address and data, before the refill read is issued. A clean victim is dropped with no write.
- R7: In write-back mode (`wtMode`=0), a write merges the bytes of `cpuWData` whose `cpuByteEn` bit is set (bit b covers data bits 8b+7:8b) into the addressed word. The line becomes Modified. A write hit causes no memory traffic, and a write miss first refills the line and then marks it Modified.
- R8: In write-through mode (`wtMode`=1), every write sends exactly one line write of the updated line to the next level before completing. The line keeps a clean state, so a later eviction of it causes no write.
- R9: A request is accepted only while `cpuReady` is 1. `cpuReady` is 0 while an access is in progress. `cpuDone` is a one-cycle pulse. `memReq` stays high with a stable `memAddr` until `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wtMode | input | 1 | 1 = write-through, 0 = write-back |
| cpuReq | input | 1 | Access request, sampled while cpuReady is 1 |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 32 | Byte address of the access |
| cpuByteEn | input | 4 | Byte enables of the write word |
| cpuWData | input | 32 | Write data |
| cpuReady | output | 1 | Idle and able to accept a request |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuHit | output | 1 | Valid with cpuDone: 1 if the access hit on first lookup |
| cpuRData | output | 32 | Read data, valid with cpuDone on reads |
| memReq | output | 1 | Next-level line request |
| memWrite | output | 1 | 1 = line write, 0 = line read |
| memAddr | output | 27 | Line address {tag, index} |
| memWData | output | 256 | Line data for writes |
| memAck | input | 1 | One-cycle completion of the next-level request |
| memRData | input | 256 | Line data, valid with memAck on reads |

## Verification
The bench fills one set until both ways are valid. It then steers the replacement bit so that clean and dirty victims are each evicted in turn. A design that updated the replacement bit wrongly would evict the line just used, and a design that ignored dirtiness would lose written data or write back clean lines; both show up in the write count and in the data read back later. A sparse byte-enable pattern catches a merge that overwrites the whole word. Write-through checks that each write reaches memory exactly once and that a line written in that mode is later dropped without a write-back, which exposes a design that marks it Modified anyway.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'b00,
    ST_SHR = 2'b01,
    ST_EXC = 2'b10,
    ST_MOD = 2'b11
  } lineState_e;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_LOOKUP,
    FS_EVICT,
    FS_FILL,
    FS_WTHRU
  } fsm_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic access;
    logic latchVictim;
    logic fillWe;
    logic selEvict;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic hit;
    logic reqWrite;
    logic victimDirtyNow;
    logic victimDirty;
  } dpStatus_t;

endpackage

// File: rtl/dcache_datapath.sv
module dcache_datapath
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wtMode,
  input  ctrlStrobe_t            strb,
  output dpStatus_t              stat,
  input  logic [ADDR_W-1:0]      cpuAddr,
  input  logic                   cpuWrite,
  input  logic [3:0]             cpuByteEn,
  input  logic [31:0]            cpuWData,
  output logic [31:0]            cpuRData,
  output logic [TAG_W+IDX_W-1:0] memAddr,
  output logic [LINE_W-1:0]      memWData,
  input  logic [LINE_W-1:0]      memRData
);

  localparam int WORDS  = LINE_BYTES / 4;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int WAYS   = 2;

  logic [TAG_W-1:0]  tagMem   [WAYS][SETS];
  lineState_e        stateMem [WAYS][SETS];
  logic [LINE_W-1:0] dataMem  [WAYS][SETS];
  logic              lruMem   [SETS];

  logic [ADDR_W-1:0] reqAddr;
  logic              reqWrite;
  logic [3:0]        reqBe;
  logic [31:0]       reqWData;
  logic              victimWayR;
  logic              hitWayR;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wsel;
  logic [WAYS-1:0]   hitVec;
  logic              hitWay;
  logic              victimWay;
  logic [LINE_W-1:0] hitLine;
  logic [LINE_W-1:0] mergedLine;

  assign idx  = reqAddr[OFF_W +: IDX_W];
  assign tag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign wsel = reqAddr[OFF_W-1 -: WSEL_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hitVec[w] = (stateMem[w][idx] != ST_INV) && (tagMem[w][idx] == tag);
  end

  assign hitWay = hitVec[1];

  // invalid ways first, way 0 preferred; then the replacement bit
  always_comb begin
    if (stateMem[0][idx] == ST_INV)      victimWay = 1'b0;
    else if (stateMem[1][idx] == ST_INV) victimWay = 1'b1;
    else                                 victimWay = lruMem[idx];
  end

  assign hitLine = dataMem[hitWay][idx];

  always_comb begin
    mergedLine = hitLine;
    for (int b = 0; b < 4; b++) begin
      if (reqBe[b]) mergedLine[wsel*32 + b*8 +: 8] = reqWData[b*8 +: 8];
    end
  end

  assign cpuRData = hitLine[wsel*32 +: 32];

  assign stat.hit            = |hitVec;
  assign stat.reqWrite       = reqWrite;
  assign stat.victimDirtyNow = (stateMem[victimWay][idx] == ST_MOD);
  assign stat.victimDirty    = (stateMem[victimWayR][idx] == ST_MOD);

  assign memAddr  = strb.selEvict ? {tagMem[victimWayR][idx], idx} : {tag, idx};
  assign memWData = strb.selEvict ? dataMem[victimWayR][idx] : dataMem[hitWayR][idx];

  // request and way registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr    <= '0;
      reqWrite   <= 1'b0;
      reqBe      <= '0;
      reqWData   <= '0;
      victimWayR <= 1'b0;
      hitWayR    <= 1'b0;
    end else begin
      if (strb.latchReq) begin
        reqAddr  <= cpuAddr;
        reqWrite <= cpuWrite;
        reqBe    <= cpuByteEn;
        reqWData <= cpuWData;
      end
      if (strb.latchVictim) victimWayR <= victimWay;
      if (strb.access)      hitWayR    <= hitWay;
    end
  end

  // coherence states and replacement bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        lruMem[s] <= 1'b0;
        for (int w = 0; w < WAYS; w++) stateMem[w][s] <= ST_INV;
      end
    end else if (strb.fillWe) begin
      stateMem[victimWayR][idx] <= ST_EXC;
    end else if (strb.access) begin
      lruMem[idx] <= ~hitWay;
      if (reqWrite && !wtMode) stateMem[hitWay][idx] <= ST_MOD;
    end
  end

  // tags and line data
  always_ff @(posedge clk) begin
    if (strb.fillWe) begin
      tagMem[victimWayR][idx]  <= tag;
      dataMem[victimWayR][idx] <= memRData;
    end else if (strb.access && reqWrite) begin
      dataMem[hitWay][idx] <= mergedLine;
    end
  end

  // R2: a tag can be resident in at most one way of a set
  assert_single_way_hit_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wtMode,
  input  logic        cpuReq,
  output logic        cpuReady,
  output logic        cpuDone,
  output logic        cpuHit,
  output logic        memReq,
  output logic        memWrite,
  input  logic        memAck,
  input  dpStatus_t   stat,
  output ctrlStrobe_t strb
);

  fsm_e state, stateNext;
  logic missFlag;

  always_comb begin
    stateNext = state;
    strb      = '0;
    cpuDone   = 1'b0;
    unique case (state)
      FS_IDLE: begin
        if (cpuReq) begin
          strb.latchReq = 1'b1;
          stateNext     = FS_LOOKUP;
        end
      end
      FS_LOOKUP: begin
        if (stat.hit) begin
          strb.access = 1'b1;
          if (stat.reqWrite && wtMode) begin
            stateNext = FS_WTHRU;
          end else begin
            cpuDone   = 1'b1;
            stateNext = FS_IDLE;
          end
        end else begin
          strb.latchVictim = 1'b1;
          stateNext        = stat.victimDirtyNow ? FS_EVICT : FS_FILL;
        end
      end
      FS_EVICT: begin
        strb.selEvict = 1'b1;
        if (memAck) stateNext = FS_FILL;
      end
      FS_FILL: begin
        if (memAck) begin
          strb.fillWe = 1'b1;
          stateNext   = FS_LOOKUP;
        end
      end
      FS_WTHRU: begin
        if (memAck) begin
          cpuDone   = 1'b1;
          stateNext = FS_IDLE;
        end
      end
      default: stateNext = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= FS_IDLE;
      missFlag <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.latchReq)         missFlag <= 1'b0;
      else if (strb.latchVictim) missFlag <= 1'b1;
    end
  end

  assign cpuReady = (state == FS_IDLE);
  assign cpuHit   = !missFlag;
  assign memReq   = (state == FS_EVICT) || (state == FS_FILL) || (state == FS_WTHRU);
  assign memWrite = (state == FS_EVICT) || (state == FS_WTHRU);

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);

  // R9: no memory traffic while idle
  assert_idle_no_mem_R9: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !memReq);

  // R9: a memory request is held until acknowledged
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

  // R6: only a Modified victim is ever written back
  assert_evict_dirty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == FS_EVICT) |-> stat.victimDirty);

endmodule

// File: rtl/dcache_2way.sv
module dcache_2way
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wtMode,
  input  logic                   cpuReq,
  input  logic                   cpuWrite,
  input  logic [ADDR_W-1:0]      cpuAddr,
  input  logic [3:0]             cpuByteEn,
  input  logic [31:0]            cpuWData,
  output logic                   cpuReady,
  output logic                   cpuDone,
  output logic                   cpuHit,
  output logic [31:0]            cpuRData,
  output logic                   memReq,
  output logic                   memWrite,
  output logic [TAG_W+IDX_W-1:0] memAddr,
  output logic [LINE_W-1:0]      memWData,
  input  logic                   memAck,
  input  logic [LINE_W-1:0]      memRData
);

  ctrlStrobe_t strb;
  dpStatus_t   stat;

  dcache_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wtMode   (wtMode),
    .cpuReq   (cpuReq),
    .cpuReady (cpuReady),
    .cpuDone  (cpuDone),
    .cpuHit   (cpuHit),
    .memReq   (memReq),
    .memWrite (memWrite),
    .memAck   (memAck),
    .stat     (stat),
    .strb     (strb)
  );

  dcache_datapath #(
    .ADDR_W     (ADDR_W),
    .SETS       (SETS),
    .LINE_BYTES (LINE_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wtMode    (wtMode),
    .strb      (strb),
    .stat      (stat),
    .cpuAddr   (cpuAddr),
    .cpuWrite  (cpuWrite),
    .cpuByteEn (cpuByteEn),
    .cpuWData  (cpuWData),
    .cpuRData  (cpuRData),
    .memAddr   (memAddr),
    .memWData  (memWData),
    .memRData  (memRData)
  );

  // R9: the line address holds steady while a request waits
  assert_mem_addr_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr));

endmodule

// File: tb/dcache_2way_tb.sv
`timescale 1ns/1ps
module dcache_2way_tb;

  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wtMode = 1'b0;
  logic         cpuReq = 1'b0;
  logic         cpuWrite = 1'b0;
  logic [31:0]  cpuAddr = '0;
  logic [3:0]   cpuByteEn = '0;
  logic [31:0]  cpuWData = '0;
  logic         cpuReady, cpuDone, cpuHit;
  logic [31:0]  cpuRData;
  logic         memReq, memWrite;
  logic [26:0]  memAddr;
  logic [255:0] memWData;
  logic         memAck = 1'b0;
  logic [255:0] memRData = '0;

  int checks = 0;
  int errors = 0;
  int rdCnt = 0;
  int wrCnt = 0;
  int wrAtRead = 0;
  int latCnt = 0;
  logic [26:0] lastRdAddr = '0;
  logic [26:0] lastWrAddr = '0;
  bit finished = 0;

  logic [255:0] memStore [logic [26:0]];
  logic [31:0]  refWords [logic [29:0]];

  always #2.5 clk = ~clk;

  dcache_2way u_dut (
    .clk(clk), .rstN(rstN), .wtMode(wtMode), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuByteEn(cpuByteEn), .cpuWData(cpuWData),
    .cpuReady(cpuReady), .cpuDone(cpuDone), .cpuHit(cpuHit), .cpuRData(cpuRData),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memWData(memWData),
    .memAck(memAck), .memRData(memRData)
  );

  function automatic logic [31:0] initWord(logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [255:0] lineRead(logic [26:0] la);
    logic [255:0] l;
    if (memStore.exists(la)) return memStore[la];
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = initWord({la, 5'b0} + 32'(i * 4));
    return l;
  endfunction

  function automatic logic [31:0] memWordOf(logic [31:0] a);
    logic [255:0] l;
    l = lineRead(a[31:5]);
    return l[a[4:2]*32 +: 32];
  endfunction

  function automatic logic [31:0] refRead(logic [31:0] a);
    if (refWords.exists(a[31:2])) return refWords[a[31:2]];
    return initWord(a);
  endfunction

  function automatic logic [31:0] mkAddr(int t, int s, int w);
    return {t[19:0], s[6:0], w[2:0], 2'b00};
  endfunction

  // next-level line responder, fixed latency
  always @(posedge clk) begin
    if (memAck) begin
      memAck <= 1'b0;
    end else if (memReq) begin
      if (latCnt == LAT - 1) begin
        latCnt <= 0;
        memAck <= 1'b1;
        if (memWrite) begin
          memStore[memAddr] = memWData;
          wrCnt <= wrCnt + 1;
          lastWrAddr <= memAddr;
        end else begin
          memRData <= lineRead(memAddr);
          rdCnt <= rdCnt + 1;
          lastRdAddr <= memAddr;
          wrAtRead <= wrCnt;
        end
      end else begin
        latCnt <= latCnt + 1;
      end
    end
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doAccess(input logic wr, input logic [31:0] a, input logic [3:0] be,
                          input logic [31:0] wd, output logic hit, output logic [31:0] rd);
    while (!cpuReady) @(negedge clk);
    cpuReq = 1'b1; cpuWrite = wr; cpuAddr = a; cpuByteEn = be; cpuWData = wd;
    @(negedge clk);
    cpuReq = 1'b0;
    check("R9", "ready low while busy", {63'b0, cpuReady}, 64'd0);
    while (!cpuDone) @(negedge clk);
    hit = cpuHit;
    rd  = cpuRData;
    @(negedge clk);
    check("R9", "done is one pulse", {63'b0, cpuDone}, 64'd0);
    if (wr) begin
      logic [31:0] v;
      v = refRead(a);
      for (int b = 0; b < 4; b++) if (be[b]) v[b*8 +: 8] = wd[b*8 +: 8];
      refWords[a[31:2]] = v;
    end
  endtask

  task automatic testReset();
    check("R1", "cpuReady after reset", {63'b0, cpuReady}, 64'd1);
    check("R1", "memReq after reset", {63'b0, memReq}, 64'd0);
  endtask

  task automatic testReadMissHit();
    logic h; logic [31:0] d; int r0, w0;
    r0 = rdCnt; w0 = wrCnt;
    doAccess(1'b0, mkAddr(1, 3, 2), 4'h0, 32'h0, h, d);
    check("R1", "cold read misses", {63'b0, h}, 64'd0);
    check("R3", "read miss data", {32'b0, d}, {32'b0, refRead(mkAddr(1, 3, 2))});
    check("R3", "one line read", 64'(rdCnt - r0), 64'd1);
    check("R3", "fill line address", {37'b0, lastRdAddr}, {37'b0, mkAddr(1, 3, 0) >> 5});
    check("R6", "clean fill no write", 64'(wrCnt - w0), 64'd0);
    r0 = rdCnt;
    doAccess(1'b0, mkAddr(1, 3, 5), 4'h0, 32'h0, h, d);
    check("R2", "second read hits", {63'b0, h}, 64'd1);
    check("R2", "hit data", {32'b0, d}, {32'b0, refRead(mkAddr(1, 3, 5))});
    check("R2", "hit no memory read", 64'(rdCnt - r0), 64'd0);
  endtask

  task automatic testWriteHitMerge();
    logic h; logic [31:0] d; int r0, w0;
    r0 = rdCnt; w0 = wrCnt;
    doAccess(1'b1, mkAddr(1, 3, 5), 4'b0101, 32'h11223344, h, d);
    check("R7", "write hit reported", {63'b0, h}, 64'd1);
    check("R7", "write hit no traffic", 64'((rdCnt - r0) + (wrCnt - w0)), 64'd0);
    doAccess(1'b0, mkAddr(1, 3, 5), 4'h0, 32'h0, h, d);
    check("R7", "byte merge readback", {32'b0, d}, {32'b0, refRead(mkAddr(1, 3, 5))});
  endtask

  task automatic testVictimAndLru();
    logic h; logic [31:0] d; int w0;
    // way 1 is still invalid: A must survive
    doAccess(1'b0, mkAddr(2, 3, 0), 4'h0, 32'h0, h, d);
    check("R4", "B misses", {63'b0, h}, 64'd0);
    doAccess(1'b0, mkAddr(1, 3, 5), 4'h0, 32'h0, h, d);
    check("R4", "A kept, invalid way used", {63'b0, h}, 64'd1);
    // replacement bit now names B's way
    w0 = wrCnt;
    doAccess(1'b0, mkAddr(3, 3, 0), 4'h0, 32'h0, h, d);
    check("R6", "clean victim dropped", 64'(wrCnt - w0), 64'd0);
    doAccess(1'b0, mkAddr(1, 3, 5), 4'h0, 32'h0, h, d);
    check("R5", "LRU spared A", {63'b0, h}, 64'd1);
    doAccess(1'b0, mkAddr(2, 3, 0), 4'h0, 32'h0, h, d);
    check("R5", "B was evicted", {63'b0, h}, 64'd0);
    // now the dirty A is least recent
    w0 = wrCnt;
    doAccess(1'b0, mkAddr(4, 3, 0), 4'h0, 32'h0, h, d);
    check("R6", "dirty victim written", 64'(wrCnt - w0), 64'd1);
    check("R6", "write-back address", {37'b0, lastWrAddr}, {37'b0, mkAddr(1, 3, 0) >> 5});
    check("R6", "write-back before refill", 64'(wrAtRead - w0), 64'd1);
    check("R6", "memory holds merged word", {32'b0, memWordOf(mkAddr(1, 3, 5))},
          {32'b0, refRead(mkAddr(1, 3, 5))});
    doAccess(1'b0, mkAddr(1, 3, 5), 4'h0, 32'h0, h, d);
    check("R6", "refetched data", {32'b0, d}, {32'b0, refRead(mkAddr(1, 3, 5))});
  endtask

  task automatic testWriteMissWb();
    logic h; logic [31:0] d; int r0, w0;
    r0 = rdCnt; w0 = wrCnt;
    doAccess(1'b1, mkAddr(5, 10, 1), 4'hF, 32'hCAFEF00D, h, d);
    check("R7", "write miss reported", {63'b0, h}, 64'd0);
    check("R7", "write miss refills", 64'(rdCnt - r0), 64'd1);
    check("R7", "write miss no write", 64'(wrCnt - w0), 64'd0);
    doAccess(1'b0, mkAddr(6, 10, 0), 4'h0, 32'h0, h, d);
    w0 = wrCnt;
    doAccess(1'b0, mkAddr(7, 10, 0), 4'h0, 32'h0, h, d);
    check("R7", "allocated line was Modified", 64'(wrCnt - w0), 64'd1);
    check("R7", "written word reached memory", {32'b0, memWordOf(mkAddr(5, 10, 1))},
          64'h00000000CAFEF00D);
  endtask

  task automatic testWriteThrough();
    logic h; logic [31:0] d; int w0;
    wtMode = 1'b1;
    w0 = wrCnt;
    doAccess(1'b1, mkAddr(8, 20, 3), 4'hF, 32'h0BADBEEF, h, d);
    check("R8", "wt write miss reported", {63'b0, h}, 64'd0);
    check("R8", "wt miss one write", 64'(wrCnt - w0), 64'd1);
    check("R8", "wt memory word", {32'b0, memWordOf(mkAddr(8, 20, 3))}, 64'h000000000BADBEEF);
    w0 = wrCnt;
    doAccess(1'b1, mkAddr(8, 20, 3), 4'b1000, 32'h77000000, h, d);
    check("R8", "wt write hit", {63'b0, h}, 64'd1);
    check("R8", "wt hit one write", 64'(wrCnt - w0), 64'd1);
    check("R8", "wt hit memory word", {32'b0, memWordOf(mkAddr(8, 20, 3))},
          {32'b0, refRead(mkAddr(8, 20, 3))});
    doAccess(1'b0, mkAddr(9, 20, 0), 4'h0, 32'h0, h, d);
    w0 = wrCnt;
    doAccess(1'b0, mkAddr(10, 20, 0), 4'h0, 32'h0, h, d);
    check("R8", "wt line never Modified", 64'(wrCnt - w0), 64'd0);
    wtMode = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadMissHit();
    testWriteHitMerge();
    testVictimAndLru();
    testWriteMissWb();
    testWriteThrough();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule